// File: doc/BRIEF.md
# Dual-Issue Pairing and Pipe Steering

This block sits in the front end of a two-wide, in-order core. Each cycle decode offers two instructions in program order, an older one in position A and a younger one in position B. The block decides which of them go to the two execution pipes in this cycle. Pipe A holds the only multiplier and the only shifter. Pipe B holds the only load/store unit. Plain ALU work can run in either pipe.

The younger instruction issues alongside the older one only when three conditions hold. The older instruction does not need pipe B. The two do not compete for pipe A. The younger does not read a register that the older writes, because no path carries a result between the pipes in the same cycle. When any condition fails, the younger instruction is held in an internal carry register. In the next cycle it takes the older position and is paired with exactly one new instruction.

The issued instructions and the carry register are registered. A downstream stall freezes all of them. `in_take` is combinational and tells decode how many input positions were consumed, so that it can shift its queue.

Top module: `dual_issue_pair`

## Requirements
- R1: Reset is synchronous and active high. In the cycle after reset both pipe enables and `hold_vld` are 0.
- R2: The instruction word is laid out as class [16:15], destination [14:10], source 1 [9:5] and source 2 [4:0]. The class codes are 0 for ALU, 1 for multiply, 2 for shift and 3 for memory. With no carry held, two valid independent instructions both issue one clock after they are presented: the older on pipe A and the younger on pipe B. `in_take` is 2.
- R3: If the older instruction is memory class, it issues alone on pipe B. A valid younger instruction is then held, whatever its class.
- R4: If both instructions are multiply or shift class, only the older issues, on pipe A, and the younger is held.
- R5: If the younger instruction reads, through either source field, the non-zero destination of the older one, the younger is held. This rule takes priority over steering.
- R6: Register 0 creates no dependence, either as a destination or as a source.
- R7: If the older instruction is ALU class and an independent younger instruction is multiply or shift, both issue: the younger on pipe A and the older on pipe B.
- R8: A held instruction is visible on `hold_ins` with `hold_vld` set. In the next cycle it is the older instruction and always issues. The new instruction in position A is the younger one, and `in_take` is 1.
- R9: If position A is invalid and no carry is held, the instruction in position B issues alone, steered by its class (memory to pipe B, anything else to pipe A). An invalid position B leaves position A to issue alone.
- R10: While `dn_stall` is 1, `in_take` is 0 and the pipe outputs and the carry register keep their values.
- R11: A pipe never receives a class it cannot execute: pipe A never receives memory, and pipe B never receives multiply or shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dn_stall | input | 1 | Downstream stall, freezes the block |
| a_vld | input | 1 | Position A (older) valid |
| a_ins | input | 17 | Position A instruction word |
| b_vld | input | 1 | Position B (younger) valid |
| b_ins | input | 17 | Position B instruction word |
| in_take | output | 2 | Input positions consumed this cycle |
| pa_en | output | 1 | Pipe A issue enable (registered) |
| pa_ins | output | 17 | Instruction issued to pipe A |
| pb_en | output | 1 | Pipe B issue enable (registered) |
| pb_ins | output | 17 | Instruction issued to pipe B |
| hold_vld | output | 1 | A younger instruction is held over |
| hold_ins | output | 17 | The held-over instruction |

## Verification
The bench exercises every class pairing and both source fields for the read-after-write hazard.

- A design that compared only one source field would issue a dependent pair.
- One that ignored register 0 would split pairs that carry no real dependence.
- A missing swap for ALU-then-multiply would hold an instruction needlessly. A wrong swap would send a multiply down pipe B.

Directed sequences target the carry path:

- A held instruction must come back as the older instruction with an `in_take` of 1. A design that accepted two here would lose an instruction.
- A dependence between the carried instruction and the new one must split the pair again.
- A stall arriving while a carry is pending must freeze everything. A leaky design would drop or duplicate the carry.
- A reset in the middle of a run must clear the carry.

// File: rtl/dip_pkg.sv
`timescale 1ns/1ps
package dip_pkg;
  parameter int REG_W = 5;
  parameter int CLS_W = 2;
  localparam int INS_W = CLS_W + 3 * REG_W;
  localparam int NPIPE = 2;
  localparam int TAKE_W = 2;

  typedef enum logic [CLS_W-1:0] {
    CLS_ALU = 2'd0,
    CLS_MUL = 2'd1,
    CLS_SHF = 2'd2,
    CLS_MEM = 2'd3
  } ucls_e;

  typedef struct packed {
    logic             vld;
    ucls_e            cls;
    logic [REG_W-1:0] dst;
    logic [REG_W-1:0] src1;
    logic [REG_W-1:0] src2;
  } slot_t;

  // needs the single multiplier or shifter, only in pipe A
  function automatic logic wants_pipe_a(input ucls_e c);
    return (c == CLS_MUL) || (c == CLS_SHF);
  endfunction

  // needs the load/store unit, only in pipe B
  function automatic logic wants_pipe_b(input ucls_e c);
    return c == CLS_MEM;
  endfunction
endpackage

// File: rtl/dip_pair_form.sv
`timescale 1ns/1ps
module dip_pair_form
  import dip_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              dn_stall,
  input  slot_t             pos_a,
  input  slot_t             pos_b,
  input  logic              keep_young,
  output slot_t             older,
  output slot_t             younger,
  output logic [TAKE_W-1:0] take,
  output slot_t             carry
);
  // Pick the pair examined this cycle: a pending carry is always the older.
  always_comb begin
    if (carry.vld) begin
      older   = carry;
      younger = pos_a;
      take    = TAKE_W'(1);
    end else if (pos_a.vld) begin
      older   = pos_a;
      younger = pos_b;
      take    = TAKE_W'(2);
    end else begin
      older   = pos_b;
      younger = '0;
      take    = TAKE_W'(2);
    end
    if (dn_stall) take = '0;
  end

  always_ff @(posedge clk) begin
    if (rst)
      carry <= '0;
    else if (!dn_stall)
      carry <= keep_young ? younger : '0;
  end

  // R10
  carry_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    dn_stall |=> $stable(carry));
endmodule

// File: rtl/dip_pair_check.sv
`timescale 1ns/1ps
module dip_pair_check
  import dip_pkg::*;
(
  input  slot_t older,
  input  slot_t younger,
  output slot_t to_pa,
  output slot_t to_pb,
  output logic  keep_young
);
  logic o_a, o_b, y_a, raw, y_ok, swap;

  always_comb begin
    o_a  = wants_pipe_a(older.cls);
    o_b  = wants_pipe_b(older.cls);
    y_a  = wants_pipe_a(younger.cls);
    raw  = (older.dst != '0) &&
           ((younger.src1 == older.dst) || (younger.src2 == older.dst));
    y_ok = older.vld && younger.vld && !o_b && !(o_a && y_a) && !raw;
    keep_young = older.vld && younger.vld && !y_ok;
    swap = y_ok && y_a;
    to_pa = '0;
    to_pb = '0;
    if (older.vld) begin
      if (o_b || swap) to_pb = older;
      else             to_pa = older;
    end
    if (y_ok) begin
      if (swap) to_pa = younger;
      else      to_pb = younger;
    end
  end
endmodule

// File: rtl/dip_issue_regs.sv
`timescale 1ns/1ps
module dip_issue_regs
  import dip_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  dn_stall,
  input  slot_t pick [NPIPE],
  output slot_t q    [NPIPE]
);
  for (genvar g = 0; g < NPIPE; g++) begin : g_pipe
    always_ff @(posedge clk) begin
      if (rst)
        q[g] <= '0;
      else if (!dn_stall)
        q[g] <= pick[g];
    end

    // R10
    pipe_frozen_chk: assert property (@(posedge clk) disable iff (rst)
      dn_stall |=> $stable(q[g]));
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (!q[0].vld && !q[1].vld));
  // R11
  pa_no_mem_chk: assert property (@(posedge clk) disable iff (rst)
    q[0].vld |-> (q[0].cls != CLS_MEM));
  // R11
  pb_no_muldiv_chk: assert property (@(posedge clk) disable iff (rst)
    q[1].vld |-> !(q[1].cls == CLS_MUL || q[1].cls == CLS_SHF));
endmodule

// File: rtl/dual_issue_pair.sv
`timescale 1ns/1ps
module dual_issue_pair
  import dip_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              dn_stall,
  input  logic              a_vld,
  input  logic [INS_W-1:0]  a_ins,
  input  logic              b_vld,
  input  logic [INS_W-1:0]  b_ins,
  output logic [TAKE_W-1:0] in_take,
  output logic              pa_en,
  output logic [INS_W-1:0]  pa_ins,
  output logic              pb_en,
  output logic [INS_W-1:0]  pb_ins,
  output logic              hold_vld,
  output logic [INS_W-1:0]  hold_ins
);
  slot_t pos_a, pos_b, older, younger, carry, to_pa, to_pb;
  slot_t pick [NPIPE];
  slot_t q    [NPIPE];
  logic  keep_young;

  assign pos_a = {a_vld, a_ins};
  assign pos_b = {b_vld, b_ins};

  dip_pair_form u_form (
    .clk(clk), .rst(rst), .dn_stall(dn_stall),
    .pos_a(pos_a), .pos_b(pos_b), .keep_young(keep_young),
    .older(older), .younger(younger), .take(in_take), .carry(carry)
  );

  dip_pair_check u_check (
    .older(older), .younger(younger),
    .to_pa(to_pa), .to_pb(to_pb), .keep_young(keep_young)
  );

  assign pick[0] = to_pa;
  assign pick[1] = to_pb;

  dip_issue_regs u_regs (
    .clk(clk), .rst(rst), .dn_stall(dn_stall), .pick(pick), .q(q)
  );

  assign pa_en    = q[0].vld;
  assign pa_ins   = q[0][INS_W-1:0];
  assign pb_en    = q[1].vld;
  assign pb_ins   = q[1][INS_W-1:0];
  assign hold_vld = carry.vld;
  assign hold_ins = carry[INS_W-1:0];

  // R8
  carry_issues_chk: assert property (@(posedge clk) disable iff (rst)
    (hold_vld && !dn_stall) |=> (pa_en || pb_en));
endmodule

// File: tb/sim_dual_issue_pair.sv
`timescale 1ns/1ps
module sim_dual_issue_pair;
  localparam logic [1:0] C_ALU = 2'd0, C_MUL = 2'd1, C_SHF = 2'd2, C_MEM = 2'd3;
  localparam int NROW = 19;

  logic clk = 0, rst = 1, dn_stall = 0;
  logic a_vld = 0, b_vld = 0;
  logic [16:0] a_ins = '0, b_ins = '0;
  logic [1:0] in_take;
  logic pa_en, pb_en, hold_vld;
  logic [16:0] pa_ins, pb_ins, hold_ins;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  dual_issue_pair u0 (
    .clk(clk), .rst(rst), .dn_stall(dn_stall),
    .a_vld(a_vld), .a_ins(a_ins), .b_vld(b_vld), .b_ins(b_ins),
    .in_take(in_take), .pa_en(pa_en), .pa_ins(pa_ins),
    .pb_en(pb_en), .pb_ins(pb_ins), .hold_vld(hold_vld), .hold_ins(hold_ins)
  );

  function automatic logic [16:0] ins(input logic [1:0] c, input int d, input int s1, input int s2);
    return {c, d[4:0], s1[4:0], s2[4:0]};
  endfunction

  typedef struct packed {
    logic av; logic [16:0] ai; logic bv; logic [16:0] bi;
    logic [1:0] tk; logic pae; logic [16:0] pai; logic pbe; logic [16:0] pbi; logic hv;
  } row_t;

  localparam row_t TBL [NROW] = '{
    // R2 independent ALU pair
    '{1'b1, ins(C_ALU,1,2,3), 1'b1, ins(C_ALU,4,5,6), 2'd2, 1'b1, ins(C_ALU,1,2,3), 1'b1, ins(C_ALU,4,5,6), 1'b0},
    // R2 multiply then memory
    '{1'b1, ins(C_MUL,7,1,2), 1'b1, ins(C_MEM,8,9,10), 2'd2, 1'b1, ins(C_MUL,7,1,2), 1'b1, ins(C_MEM,8,9,10), 1'b0},
    // R3 older memory, younger ALU held
    '{1'b1, ins(C_MEM,3,4,5), 1'b1, ins(C_ALU,6,7,8), 2'd2, 1'b0, 17'd0, 1'b1, ins(C_MEM,3,4,5), 1'b1},
    // R3 two memory ops
    '{1'b1, ins(C_MEM,3,4,5), 1'b1, ins(C_MEM,9,1,2), 2'd2, 1'b0, 17'd0, 1'b1, ins(C_MEM,3,4,5), 1'b1},
    // R4 multiply then shift
    '{1'b1, ins(C_MUL,2,3,4), 1'b1, ins(C_SHF,9,10,11), 2'd2, 1'b1, ins(C_MUL,2,3,4), 1'b0, 17'd0, 1'b1},
    // R4 shift then multiply
    '{1'b1, ins(C_SHF,2,3,4), 1'b1, ins(C_MUL,9,10,11), 2'd2, 1'b1, ins(C_SHF,2,3,4), 1'b0, 17'd0, 1'b1},
    // R5 dependence through source 1
    '{1'b1, ins(C_ALU,5,1,2), 1'b1, ins(C_ALU,6,5,3), 2'd2, 1'b1, ins(C_ALU,5,1,2), 1'b0, 17'd0, 1'b1},
    // R5 dependence through source 2
    '{1'b1, ins(C_ALU,5,1,2), 1'b1, ins(C_MEM,6,3,5), 2'd2, 1'b1, ins(C_ALU,5,1,2), 1'b0, 17'd0, 1'b1},
    // R6 register 0 on both sides
    '{1'b1, ins(C_ALU,0,1,2), 1'b1, ins(C_ALU,6,0,0), 2'd2, 1'b1, ins(C_ALU,0,1,2), 1'b1, ins(C_ALU,6,0,0), 1'b0},
    // R6 shift writing r0, memory reading r0
    '{1'b1, ins(C_SHF,0,3,4), 1'b1, ins(C_MEM,5,0,0), 2'd2, 1'b1, ins(C_SHF,0,3,4), 1'b1, ins(C_MEM,5,0,0), 1'b0},
    // R7 ALU then multiply swaps pipes
    '{1'b1, ins(C_ALU,1,2,3), 1'b1, ins(C_MUL,4,5,6), 2'd2, 1'b1, ins(C_MUL,4,5,6), 1'b1, ins(C_ALU,1,2,3), 1'b0},
    // R7 ALU then shift swaps pipes
    '{1'b1, ins(C_ALU,1,2,3), 1'b1, ins(C_SHF,9,10,11), 2'd2, 1'b1, ins(C_SHF,9,10,11), 1'b1, ins(C_ALU,1,2,3), 1'b0},
    // R5 over R7: dependent multiply held, no swap
    '{1'b1, ins(C_ALU,4,2,3), 1'b1, ins(C_MUL,6,4,1), 2'd2, 1'b1, ins(C_ALU,4,2,3), 1'b0, 17'd0, 1'b1},
    // R9 position A invalid, memory moves up to pipe B
    '{1'b0, ins(C_ALU,1,1,1), 1'b1, ins(C_MEM,2,3,4), 2'd2, 1'b0, 17'd0, 1'b1, ins(C_MEM,2,3,4), 1'b0},
    // R9 position A invalid, multiply moves up to pipe A
    '{1'b0, ins(C_ALU,1,1,1), 1'b1, ins(C_MUL,2,3,4), 2'd2, 1'b1, ins(C_MUL,2,3,4), 1'b0, 17'd0, 1'b0},
    // R9 position B invalid
    '{1'b1, ins(C_ALU,5,6,7), 1'b0, ins(C_ALU,5,5,5), 2'd2, 1'b1, ins(C_ALU,5,6,7), 1'b0, 17'd0, 1'b0},
    // R9 nothing valid
    '{1'b0, 17'd0, 1'b0, 17'd0, 2'd2, 1'b0, 17'd0, 1'b0, 17'd0, 1'b0},
    // R3 memory then multiply is not swapped
    '{1'b1, ins(C_MEM,3,4,5), 1'b1, ins(C_MUL,6,7,8), 2'd2, 1'b0, 17'd0, 1'b1, ins(C_MEM,3,4,5), 1'b1},
    // R2 multiply then ALU
    '{1'b1, ins(C_MUL,1,2,3), 1'b1, ins(C_ALU,4,5,6), 2'd2, 1'b1, ins(C_MUL,1,2,3), 1'b1, ins(C_ALU,4,5,6), 1'b0}
  };

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic drive(input logic av, input logic [16:0] ai, input logic bv, input logic [16:0] bi);
    a_vld = av; a_ins = ai; b_vld = bv; b_ins = bi;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 state after reset
    chk("R1 pa_en", 32'(pa_en), 0);
    chk("R1 pb_en", 32'(pb_en), 0);
    chk("R1 hold_vld", 32'(hold_vld), 0);

    for (int i = 0; i < NROW; i++) begin
      drive(TBL[i].av, TBL[i].ai, TBL[i].bv, TBL[i].bi);
      #1;
      chk($sformatf("row %0d take", i), 32'(in_take), 32'(TBL[i].tk));
      @(negedge clk);
      chk($sformatf("row %0d pa_en", i), 32'(pa_en), 32'(TBL[i].pae));
      if (TBL[i].pae) chk($sformatf("row %0d pa_ins", i), 32'(pa_ins), 32'(TBL[i].pai));
      chk($sformatf("row %0d pb_en", i), 32'(pb_en), 32'(TBL[i].pbe));
      if (TBL[i].pbe) chk($sformatf("row %0d pb_ins", i), 32'(pb_ins), 32'(TBL[i].pbi));
      chk($sformatf("row %0d hold_vld", i), 32'(hold_vld), 32'(TBL[i].hv));
      if (TBL[i].hv) chk($sformatf("row %0d R8 hold_ins", i), 32'(hold_ins), 32'(TBL[i].bi));
      // flush cycle: R8 a held carry issues with take of 1
      drive(0, '0, 0, '0);
      #1;
      chk($sformatf("row %0d R8 flush take", i), 32'(in_take), TBL[i].hv ? 1 : 2);
      @(negedge clk);
      chk($sformatf("row %0d R8 carry cleared", i), 32'(hold_vld), 0);
      if (TBL[i].hv) chk($sformatf("row %0d R8 carry issued", i), 32'(pa_en | pb_en), 1);
    end

    // R8 carry pairs with one new instruction
    drive(1, ins(C_MEM,3,4,5), 1, ins(C_ALU,6,7,8));
    @(negedge clk);
    chk("R8 hold_ins", 32'(hold_ins), 32'(ins(C_ALU,6,7,8)));
    drive(1, ins(C_ALU,10,11,12), 1, ins(C_ALU,13,1,1));
    #1;
    chk("R8 take one", 32'(in_take), 1);
    @(negedge clk);
    chk("R8 carry on pipe A", 32'(pa_ins), 32'(ins(C_ALU,6,7,8)));
    chk("R8 new on pipe B", 32'(pb_ins), 32'(ins(C_ALU,10,11,12)));
    chk("R8 both enabled", 32'({pa_en, pb_en}), 3);
    chk("R8 no hold", 32'(hold_vld), 0);

    // R8 with R5: new instruction depends on the carried one
    drive(1, ins(C_MEM,3,4,5), 1, ins(C_ALU,6,7,8));
    @(negedge clk);
    drive(1, ins(C_ALU,10,6,1), 1, ins(C_ALU,13,1,1));
    @(negedge clk);
    chk("R5 carry issues", 32'({pa_en, pa_ins}), 32'({1'b1, ins(C_ALU,6,7,8)}));
    chk("R5 pipe B idle", 32'(pb_en), 0);
    chk("R5 re-held", 32'({hold_vld, hold_ins}), 32'({1'b1, ins(C_ALU,10,6,1)}));

    // R10 stall freezes everything
    dn_stall = 1;
    drive(1, ins(C_ALU,20,1,1), 1, ins(C_ALU,21,1,1));
    #1;
    chk("R10 take zero", 32'(in_take), 0);
    @(negedge clk);
    chk("R10 pipe A frozen", 32'({pa_en, pa_ins}), 32'({1'b1, ins(C_ALU,6,7,8)}));
    chk("R10 pipe B frozen", 32'(pb_en), 0);
    chk("R10 carry frozen", 32'({hold_vld, hold_ins}), 32'({1'b1, ins(C_ALU,10,6,1)}));
    dn_stall = 0;
    drive(0, '0, 0, '0);
    #1;
    chk("R10 release take", 32'(in_take), 1);
    @(negedge clk);
    chk("R10 carry drains", 32'({pa_en, pa_ins}), 32'({1'b1, ins(C_ALU,10,6,1)}));
    chk("R10 carry empty", 32'(hold_vld), 0);

    // R1 reset in mid-run clears a pending carry
    drive(1, ins(C_MEM,3,4,5), 1, ins(C_ALU,6,7,8));
    @(negedge clk);
    rst = 1;
    drive(0, '0, 0, '0);
    @(negedge clk);
    chk("R1 mid reset hold", 32'(hold_vld), 0);
    chk("R1 mid reset pipes", 32'({pa_en, pb_en}), 0);
    rst = 0;
    @(negedge clk);
    finish_run();
  end
endmodule